// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break Detection

This block turns an asynchronous serial line into parallel characters. An external enable, `sample_tick`, pulses at sixteen times the bit rate. The receiver uses it to find the falling edge of each start bit and to confirm that edge half a bit period later. It then reads every later bit near the middle of its bit period. Before any of this logic sees the line, the line passes through a two-stage synchronizer.

The character format is chosen at run time: five to nine data bits, no parity or even or odd parity, and one or two stop bits. For each completed character the block gives one strobe cycle, the data right-aligned, and parity and framing error flags. These results stay unchanged until the next strobe. A separate break flag rises when the line has been low for longer than one whole character at the current format. It stays up, without repeating, until the line goes high again.

Top module: `uart_rx16`

## Requirements
- R1: While reset is low, and after it until the first character arrives, `rx_valid`, `rx_data`, `rx_parity_err`, `rx_frame_err` and `rx_break` are all zero.
- R2: Each received character produces exactly one cycle of `rx_valid`, in the clock cycle after the last stop bit is sampled. `rx_data` holds the data bits with the first received bit in bit 0 and the unused upper bits at zero.
- R3: `cfg_data_bits` gives the data-bit count directly as a binary number. The values 5, 6, 7, 8 and 9 are received correctly. Values below 5 act as 5 and values above 9 act as 9.
- R4: `cfg_parity` selects the parity mode: 0 or 3 means no parity bit, 1 means even parity and 2 means odd parity. `rx_parity_err` is 1 when the received parity bit breaks the selected rule over the data bits. It is always 0 when there is no parity bit.
- R5: `cfg_two_stop` = 1 selects two stop bits and 0 selects one. `rx_frame_err` is 1 when any expected stop bit is sampled low. If the last stop bit is low, the receiver waits for the line to go high before it looks for a new start bit.
- R6: A low pulse that has ended before the check half a bit after the falling edge is discarded as a false start, and no strobe follows.
- R7: A start bit that follows the last stop bit directly, with no idle time, is received correctly.
- R8: `rx_break` rises once after the line has been low for more than 16 × (1 + data bits + parity bit + stop bits) ticks. It stays high while the line stays low and clears when the line returns high.
- R9: `rx_data`, `rx_parity_err` and `rx_frame_err` do not change between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_data_bits | input | 4 | Data-bit count, 5 to 9 |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rx_data | output | MAX_BITS | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe per character |
| rx_parity_err | output | 1 | Parity check failed on the last character |
| rx_frame_err | output | 1 | A stop bit was low on the last character |
| rx_break | output | 1 | Line held low longer than one character |

## Verification
The bench builds the receiver with its default parameters: 16 ticks per bit, up to nine data bits and two synchronizer stages. It supplies one tick every four clocks, so a whole bit period lasts 64 clocks. This makes every format practical to run within the time budget: all five data lengths, all parity settings and both stop-bit counts. The same settings make the break threshold of 160 ticks reachable and let the bench sample the break flag on both sides of that threshold. It also drives frames back to back, sends short false-start pulses, and corrupts the parity bit and each of the stop bits.

// File: rtl/urx_pkg.sv
// Shared types of the serial receiver: parity selection codes and the
// states of the character deframer.
package urx_pkg;

    // Parity selection as carried on the configuration port (3 = none).
    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE2 = 2'd3
    } par_mode_e;

    // Deframer state.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PAR    = 3'd3,
        ST_STOP   = 3'd4,
        ST_WAITHI = 3'd5
    } rx_state_e;

endpackage

// File: rtl/urx_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes: the line idles high, so every stage resets to 1 and reset
// produces no false falling edge.
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_fmt.sv
// Decodes the run-time format configuration into the values the deframer
// and the break detector use.
// Assumes: the configuration is held stable while a character is in flight.
module urx_fmt
    import urx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 9,
    parameter int IDX_W    = $clog2(MAX_BITS),
    parameter int BRK_W    = $clog2(OVS * (MAX_BITS + 4) + 1)
) (
    input  logic [3:0]       cfg_data_bits,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_two_stop,
    output logic [IDX_W-1:0] last_idx,
    output logic             par_en,
    output logic             par_odd,
    output logic             two_stop,
    output logic [BRK_W-1:0] char_ticks
);
    localparam int FB_W = 5;

    logic [3:0]      nbits;
    logic [FB_W-1:0] frame_bits;
    par_mode_e       pmode;

    // Clamp the requested data-bit count to the supported range.
    always_comb begin
        if (cfg_data_bits < 4'(MIN_BITS))      nbits = 4'(MIN_BITS);
        else if (cfg_data_bits > 4'(MAX_BITS)) nbits = 4'(MAX_BITS);
        else                                   nbits = cfg_data_bits;
    end

    // Decode parity mode and the whole-character length in ticks.
    always_comb begin
        pmode      = par_mode_e'(cfg_parity);
        par_en     = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
        par_odd    = (pmode == PAR_ODD);
        two_stop   = cfg_two_stop;
        last_idx   = IDX_W'(nbits - 4'd1);
        frame_bits = FB_W'(1) + FB_W'(nbits) + FB_W'(par_en) + FB_W'(1) + FB_W'(cfg_two_stop);
        char_ticks = BRK_W'(frame_bits) * BRK_W'(OVS);
    end
endmodule

// File: rtl/urx_break.sv
// Break detector: counts sample ticks while the synchronized line is low and
// raises a level flag once the low time exceeds one character; the flag
// clears on the first clock that sees the line high.
// Assumes: char_ticks fits BRK_W and the counter saturates there.
module urx_break #(
    parameter int BRK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic [BRK_W-1:0] char_ticks,
    output logic             brk
);
    logic [BRK_W-1:0] low_cnt;

    // Measure low time; flag the tick that goes past one character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            brk     <= 1'b0;
        end else if (line) begin
            low_cnt <= '0;
            brk     <= 1'b0;
        end else if (tick) begin
            if (low_cnt >= char_ticks) brk     <= 1'b1;
            else                       low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/urx_deframer.sv
// Character deframer running on the oversampling tick: validates the start
// bit at half a bit, samples data, parity and stop bits mid-bit, and
// publishes the character with its error flags on a one-cycle strobe.
// Assumes: line is already synchronized; the format is stable per character.
module urx_deframer
    import urx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int MAX_BITS = 9,
    parameter int IDX_W    = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic [IDX_W-1:0]    last_idx,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    output logic [MAX_BITS-1:0] data_o,
    output logic                valid_o,
    output logic                perr_o,
    output logic                ferr_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OVS - 1);

    rx_state_e           state;
    logic [CNT_W-1:0]    tcnt;
    logic [IDX_W-1:0]    bidx;
    logic [MAX_BITS-1:0] shreg;
    logic                par_bit;
    logic                stop_bad;
    logic                stop_second;
    logic                mid_full;
    logic                mid_half;

    // Tick positions where the current bit is due for sampling.
    always_comb begin
        mid_full = tick && (tcnt == FULL_END);
        mid_half = tick && (tcnt == HALF_END);
    end

    // Frame sequencing, sampling and result publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tcnt        <= '0;
            bidx        <= '0;
            shreg       <= '0;
            par_bit     <= 1'b0;
            stop_bad    <= 1'b0;
            stop_second <= 1'b0;
            data_o      <= '0;
            valid_o     <= 1'b0;
            perr_o      <= 1'b0;
            ferr_o      <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !line) begin
                        state <= ST_START;
                        tcnt  <= '0;
                    end
                end
                ST_START: begin
                    if (mid_half) begin
                        tcnt <= '0;
                        if (!line) begin
                            state <= ST_DATA;
                            bidx  <= '0;
                            shreg <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (mid_full) begin
                        tcnt        <= '0;
                        shreg[bidx] <= line;
                        if (bidx == last_idx) begin
                            state       <= par_en ? ST_PAR : ST_STOP;
                            stop_bad    <= 1'b0;
                            stop_second <= 1'b0;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (mid_full) begin
                        tcnt    <= '0;
                        par_bit <= line;
                        state   <= ST_STOP;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (mid_full) begin
                        tcnt <= '0;
                        if (two_stop && !stop_second) begin
                            stop_second <= 1'b1;
                            stop_bad    <= !line;
                        end else begin
                            valid_o <= 1'b1;
                            data_o  <= shreg;
                            ferr_o  <= stop_bad || !line;
                            perr_o  <= par_en && ((^shreg) ^ par_bit ^ par_odd);
                            state   <= line ? ST_IDLE : ST_WAITHI;
                        end
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_WAITHI: begin
                    if (line) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx16.sv
// Top of the oversampling serial receiver: synchronizer, format decoder,
// deframer and break detector.
// Assumes: sample_tick is a single-cycle pulse at OVS times the bit rate and
// the configuration changes only while the line is idle.
module uart_rx16
    import urx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int MAX_BITS    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic                rxd,
    input  logic [3:0]          cfg_data_bits,
    input  logic [1:0]          cfg_parity,
    input  logic                cfg_two_stop,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_parity_err,
    output logic                rx_frame_err,
    output logic                rx_break
);
    localparam int IDX_W = $clog2(MAX_BITS);
    localparam int BRK_W = $clog2(OVS * (MAX_BITS + 4) + 1);

    logic             line_s;
    logic [IDX_W-1:0] last_idx;
    logic             par_en;
    logic             par_odd;
    logic             two_stop;
    logic [BRK_W-1:0] char_ticks;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    urx_fmt #(
        .OVS     (OVS),
        .MIN_BITS(5),
        .MAX_BITS(MAX_BITS),
        .IDX_W   (IDX_W),
        .BRK_W   (BRK_W)
    ) u_fmt (
        .cfg_data_bits(cfg_data_bits),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .last_idx     (last_idx),
        .par_en       (par_en),
        .par_odd      (par_odd),
        .two_stop     (two_stop),
        .char_ticks   (char_ticks)
    );

    urx_deframer #(
        .OVS     (OVS),
        .MAX_BITS(MAX_BITS),
        .IDX_W   (IDX_W)
    ) u_deframe (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_tick),
        .line    (line_s),
        .last_idx(last_idx),
        .par_en  (par_en),
        .par_odd (par_odd),
        .two_stop(two_stop),
        .data_o  (rx_data),
        .valid_o (rx_valid),
        .perr_o  (rx_parity_err),
        .ferr_o  (rx_frame_err)
    );

    urx_break #(.BRK_W(BRK_W)) u_break (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .line      (line_s),
        .char_ticks(char_ticks),
        .brk       (rx_break)
    );
endmodule

// File: rtl/uart_rx16_checks.sv
// Protocol checks on the receiver ports, attached by bind.
// Assumes: the configuration is stable around each strobe and the
// synchronizer has two stages.
module uart_rx16_checks #(
    parameter int MAX_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rxd,
    input logic [1:0]          cfg_parity,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_valid,
    input logic                rx_parity_err,
    input logic                rx_frame_err,
    input logic                rx_break
);
    // R2: the strobe never lasts two cycles.
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: results only move together with a strobe.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(rx_data) && $stable(rx_parity_err) && $stable(rx_frame_err)) || rx_valid);

    // R4: no parity error without a parity bit.
    p_perr_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (cfg_parity == 2'd0 || cfg_parity == 2'd3)) |-> !rx_parity_err);

    // R8: a line high for three samples leaves no break flag.
    p_brk_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rxd, 1) && $past(rxd, 2) && $past(rxd, 3)) |-> !rx_break);

    // R8: the break flag rises only from a low line.
    p_brk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_break) |-> !$past(rxd, 3));
endmodule

bind uart_rx16 uart_rx16_checks #(.MAX_BITS(MAX_BITS)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxd          (rxd),
    .cfg_parity   (cfg_parity),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_parity_err(rx_parity_err),
    .rx_frame_err (rx_frame_err),
    .rx_break     (rx_break)
);

// File: tb/uart_rx16_test.sv
// Scoreboard bench: the frame driver queues the expected characters and a
// monitor compares them with every strobe.
module uart_rx16_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [3:0] cfg_data_bits = 4'd8;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       rx_parity_err;
    logic       rx_frame_err;
    logic       rx_break;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int brk_rises = 0;
    bit done = 1'b0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    uart_rx16 uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_tick  (sample_tick),
        .rxd          (rxd),
        .cfg_data_bits(cfg_data_bits),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_parity_err(rx_parity_err),
        .rx_frame_err (rx_frame_err),
        .rx_break     (rx_break)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Tick source: one clock high every TICK_DIV clocks.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            sample_tick = 1'b1;
            @(negedge clk);
            sample_tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each strobe with the head of the scoreboard.
    logic prev_valid = 1'b0;
    logic prev_brk = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            strobes++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected strobe", {21'd0, rx_frame_err, rx_parity_err, rx_data}, 32'd0);
            end else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rx_frame_err, rx_parity_err, rx_data} == e, t,
                    {21'd0, rx_frame_err, rx_parity_err, rx_data}, {21'd0, e});
            end
            chk(!prev_valid, "R2 strobe width", 32'(prev_valid), 32'd0);
        end
        if (rst_n && rx_break && !prev_brk) brk_rises++;
        prev_valid = rx_valid;
        prev_brk   = rx_break;
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!sample_tick) @(posedge clk);
        end
    endtask

    task automatic line_ticks(input logic v, input int n);
        @(negedge clk);
        rxd = v;
        wait_ticks(n);
    endtask

    task automatic set_fmt(input int nb, input int pm, input bit two);
        @(negedge clk);
        cfg_data_bits = 4'(nb);
        cfg_parity    = 2'(pm);
        cfg_two_stop  = two;
    endtask

    // Drive one character and queue its expected result.
    task automatic send_frame(input logic [8:0] d, input int nb, input int pm, input bit two,
                              input bit bad_par, input bit bad_s1, input bit bad_s2, input string tag);
        logic [8:0] m;
        logic       pb;
        bit         has_par;
        int         n;
        n = (nb < 5) ? 5 : (nb > 9) ? 9 : nb;
        m = d & 9'((10'h1 << n) - 10'h1);
        has_par = (pm == 1) || (pm == 2);
        exp_q.push_back({bad_s1 || (two && bad_s2), has_par && bad_par, m});
        tag_q.push_back(tag);
        line_ticks(1'b0, 16);
        for (int i = 0; i < n; i++) line_ticks(m[i], 16);
        if (has_par) begin
            pb = (^m) ^ (pm == 2) ^ bad_par;
            line_ticks(pb, 16);
        end
        line_ticks(!bad_s1, 16);
        if (two) line_ticks(!bad_s2, 16);
    endtask

    task automatic drain(input string tag);
        line_ticks(1'b1, 40);
        chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        logic [8:0] held;
        int         s0;
        // R1: reset state
        repeat (5) @(negedge clk);
        chk({rx_valid, rx_data, rx_parity_err, rx_frame_err, rx_break} == '0, "R1 in reset",
            32'({rx_valid, rx_data, rx_parity_err, rx_frame_err, rx_break}), 32'd0);
        rst_n = 1'b1;
        wait_ticks(20);
        chk({rx_valid, rx_data, rx_parity_err, rx_frame_err, rx_break} == '0, "R1 after reset",
            32'({rx_valid, rx_data, rx_parity_err, rx_frame_err, rx_break}), 32'd0);

        // R2: eight data bits, first bit in bit 0
        set_fmt(8, 0, 0);
        send_frame(9'h0A5, 8, 0, 0, 0, 0, 0, "R2 8N1 a5");
        send_frame(9'h001, 8, 0, 0, 0, 0, 0, "R2 8N1 01");
        send_frame(9'h080, 8, 0, 0, 0, 0, 0, "R2 8N1 80");
        drain("R2 drain");

        // R3: every data length, plus clamping
        for (int nb = 5; nb <= 9; nb++) begin
            set_fmt(nb, 0, 0);
            send_frame(9'h1B6, nb, 0, 0, 0, 0, 0, "R3 length");
            send_frame(9'h149, nb, 0, 0, 0, 0, 0, "R3 length");
        end
        set_fmt(3, 0, 0);
        send_frame(9'h1FF, 3, 0, 0, 0, 0, 0, "R3 clamp low");
        set_fmt(12, 0, 0);
        send_frame(9'h155, 12, 0, 0, 0, 0, 0, "R3 clamp high");
        drain("R3 drain");

        // R4: parity modes
        set_fmt(8, 1, 0);
        send_frame(9'h0A5, 8, 1, 0, 0, 0, 0, "R4 even ok");
        send_frame(9'h0A4, 8, 1, 0, 1, 0, 0, "R4 even bad");
        set_fmt(8, 2, 0);
        send_frame(9'h0A5, 8, 2, 0, 0, 0, 0, "R4 odd ok");
        send_frame(9'h0A4, 8, 2, 0, 1, 0, 0, "R4 odd bad");
        set_fmt(7, 2, 0);
        send_frame(9'h03C, 7, 2, 0, 1, 0, 0, "R4 odd bad 7 bits");
        set_fmt(8, 3, 0);
        send_frame(9'h0C3, 8, 3, 0, 0, 0, 0, "R4 mode 3 none");
        drain("R4 drain");

        // R5: stop bits and framing errors
        set_fmt(8, 0, 1);
        send_frame(9'h05A, 8, 0, 1, 0, 0, 0, "R5 two stop ok");
        send_frame(9'h05A, 8, 0, 1, 0, 1, 0, "R5 first stop bad");
        send_frame(9'h033, 8, 0, 1, 0, 0, 1, "R5 second stop bad");
        line_ticks(1'b1, 4);
        set_fmt(8, 1, 0);
        send_frame(9'h0F0, 8, 1, 0, 0, 1, 0, "R5 one stop bad");
        drain("R5 drain");

        // R6: false starts
        set_fmt(8, 0, 0);
        s0 = strobes;
        line_ticks(1'b0, 3);
        line_ticks(1'b1, 40);
        line_ticks(1'b0, 5);
        line_ticks(1'b1, 40);
        chk(strobes == s0, "R6 false start", 32'(strobes), 32'(s0));
        send_frame(9'h0E7, 8, 0, 0, 0, 0, 0, "R6 after false start");
        drain("R6 drain");

        // R7: back to back characters
        set_fmt(9, 1, 0);
        send_frame(9'h1C3, 9, 1, 0, 0, 0, 0, "R7 b2b 1");
        send_frame(9'h03C, 9, 1, 0, 0, 0, 0, "R7 b2b 2");
        send_frame(9'h100, 9, 1, 0, 0, 0, 0, "R7 b2b 3");
        set_fmt(5, 0, 1);
        send_frame(9'h015, 5, 0, 1, 0, 0, 0, "R7 b2b 4");
        send_frame(9'h00A, 5, 0, 1, 0, 0, 0, "R7 b2b 5");
        drain("R7 drain");

        // R9: results held until the next strobe
        held = rx_data;
        line_ticks(1'b1, 100);
        chk(rx_data == held && !rx_frame_err && !rx_parity_err, "R9 hold idle", 32'(rx_data), 32'(held));
        set_fmt(8, 0, 0);
        exp_q.push_back({2'b00, 9'h066});
        tag_q.push_back("R9 next char");
        line_ticks(1'b0, 16);
        line_ticks(1'b0, 16);
        line_ticks(1'b1, 16);
        line_ticks(1'b1, 16);
        chk(rx_data == held, "R9 hold during char", 32'(rx_data), 32'(held));
        line_ticks(1'b0, 16);
        line_ticks(1'b0, 16);
        line_ticks(1'b1, 16);
        line_ticks(1'b1, 16);
        line_ticks(1'b0, 16);
        line_ticks(1'b1, 16);
        drain("R9 drain");

        // R8: break, 8N1 -> 160 ticks per character
        s0 = brk_rises;
        exp_q.push_back({2'b10, 9'h000});
        tag_q.push_back("R8 break char");
        line_ticks(1'b0, 150);
        chk(!rx_break, "R8 before threshold", 32'(rx_break), 32'd0);
        wait_ticks(30);
        chk(rx_break, "R8 past threshold", 32'(rx_break), 32'd1);
        wait_ticks(200);
        chk(rx_break && brk_rises == s0 + 1, "R8 single rise", 32'(brk_rises - s0), 32'd1);
        line_ticks(1'b1, 3);
        chk(!rx_break, "R8 cleared", 32'(rx_break), 32'd0);
        drain("R8 drain");
        send_frame(9'h09C, 8, 0, 0, 0, 0, 0, "R8 recovery");
        drain("R8 recovery drain");
        chk(brk_rises == s0 + 1, "R8 no second rise", 32'(brk_rises - s0), 32'd1);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) chk(1'b0, "watchdog", 32'(cyc), 32'(WATCHDOG));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule